// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible register slave of a colour LCD controller. It answers a simple APB-style bus inside a 4 KB window. The window holds:

- four display timing words;
- the frame base addresses for the upper and lower panel halves;
- the interrupt mask;
- the control word;
- the interrupt status views and the clear register;
- a 128-word palette store;
- a read-only identification area.

From the stored words it derives the panel geometry and the mode flags that the raster and fetch logic downstream consume. It asserts an interrupt while any status bit that the mask allows is set.

The fetch logic raises individual status bits through a set input. Software lowers them by writing ones to the clear register. Any write to a timing or control register causes a one-cycle invalidate pulse, so that downstream state can be rebuilt. The live current-address counters are not implemented here and read as zero.

Top module: `lcd_regbank`

## Requirements
- R1: After a write, word indices 0 to 3 (timing words), 4 (upper base) and 5 (lower base) read back all 32 written bits. Index 7 (control) also reads back all 32 bits. Index 6 (mask) reads back the low 4 written bits, with zeros above them. The word index is paddr[11:2].
- R2: Byte offsets 0xFE0 to 0xFFF are read-only. Word k of that area (k = paddr[4:2]) reads as one byte from this list, indexed from k = 0: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Each byte is zero-extended.
- R3: Byte offsets 0x200 to 0x3FF hold 128 palette words at entry (paddr-0x200)>>2. Each entry is written as, and reads back as, raw 32-bit data.
- R4: line_pixels equals ((timing0 & 0xFC) + 4) * 4, which gives 16 for 0x00 and 1024 for 0xFF. frame_lines equals (timing1 & 0x3FF) + 1.
- R5: The control word maps to the outputs as follows. Bit 0 is enable. Bits 3:1 drive depth. Bit 8 drives bgr_swap. Bit 9 drives be_bytes. Bit 10 drives be_pixels. Bit 11 is power. enabled is 1 only when bit 0 and bit 11 are both 1.
- R6: Each status bit is set by a 1 on the matching sts_set bit, and it then stays set. Index 8 reads the raw status. A set and a clear of the same bit in the same cycle leave the bit set.
- R7: Writing to index 10 clears every status bit that is 1 in pwdata[3:0]. The other status bits are unchanged. Index 10 reads as zero.
- R8: Index 9 reads the raw status ANDed with the mask. irq is 1 exactly while that value is nonzero.
- R9: Indices 8 to 12, and offsets outside every mapped area, are not writable. Indices 11 and 12 and every unmapped offset read zero. Writes to them change no register.
- R10: inval is high for exactly one cycle, in the cycle after the access cycle of a write to index 0, 1, 2, 3 or 7. It is low at all other times.
- R11: After reset, every register, every palette word, the status, irq, enabled and inval are zero. At that point line_pixels reads 16 and frame_lines reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| sts_set | input | 4 | Per-bit status set from fetch logic |
| irq | output | 1 | Masked status nonzero |
| enabled | output | 1 | Enable and power bits both set |
| depth | output | 3 | Pixel depth code |
| bgr_swap | output | 1 | Swap red and blue |
| be_bytes | output | 1 | Big-endian byte order |
| be_pixels | output | 1 | Big-endian pixel order within bytes |
| line_pixels | output | 11 | Active pixels per line |
| frame_lines | output | 11 | Active lines per frame |
| upper_base | output | 32 | Upper panel frame base |
| lower_base | output | 32 | Lower panel frame base |
| inval | output | 1 | One-cycle pulse after a timing or control write |

## Verification
The bench builds the block with its default parameters: four status bits and 128 palette words. With four status bits, every set, clear and mask combination of the status field is within reach. With 128 palette words, the first and last palette entries sit at offsets 0x200 and 0x3FC, and the neighbouring unmapped offsets can be probed. The timing fields are driven to both ends of their range, and to values with stray upper bits, so that the decode limits of 16 and 1024 are both exercised.

// File: rtl/lcd_regbank.sv
module lcd_regbank #(
  parameter int NSTAT     = 4,
  parameter int PAL_WORDS = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [11:0]      paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  input  logic [NSTAT-1:0] sts_set,
  output logic             irq,
  output logic             enabled,
  output logic [2:0]       depth,
  output logic             bgr_swap,
  output logic             be_bytes,
  output logic             be_pixels,
  output logic [10:0]      line_pixels,
  output logic [10:0]      frame_lines,
  output logic [31:0]      upper_base,
  output logic [31:0]      lower_base,
  output logic             inval
);
  localparam int PAL_AW = $clog2(PAL_WORDS);
  localparam logic [9:0] PAL_LO = 10'd128;
  localparam logic [9:0] PAL_HI = 10'(128 + PAL_WORDS);

  logic [31:0]      tim [4];
  logic [31:0]      ctrl;
  logic [NSTAT-1:0] mask, raw;
  logic [31:0]      pal [PAL_WORDS];

  wire [9:0] idx    = paddr[11:2];
  wire       wr     = psel & penable & pwrite;
  wire       in_pal = (idx >= PAL_LO) && (idx < PAL_HI);
  wire       in_id  = (paddr[11:5] == 7'h7F);
  wire       in_reg = (idx < 10'd16);
  wire [PAL_AW-1:0] pal_idx = PAL_AW'(idx - PAL_LO);
  wire       cfg_wr = wr && in_reg && (idx < 10'd4 || idx == 10'd7);
  wire [NSTAT-1:0] clr = (wr && idx == 10'd10) ? pwdata[NSTAT-1:0] : '0;
  wire [NSTAT-1:0] masked = raw & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim[i] <= '0;
      upper_base <= '0;
      lower_base <= '0;
      ctrl       <= '0;
      mask       <= '0;
      raw        <= '0;
      inval      <= 1'b0;
    end else begin
      raw   <= (raw & ~clr) | sts_set;
      inval <= cfg_wr;
      if (wr && in_reg) begin
        case (idx)
          10'd0, 10'd1, 10'd2, 10'd3: tim[idx[1:0]] <= pwdata;
          10'd4: upper_base <= pwdata;
          10'd5: lower_base <= pwdata;
          10'd6: mask       <= pwdata[NSTAT-1:0];
          10'd7: ctrl       <= pwdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_WORDS; i++) pal[i] <= '0;
    end else if (wr && in_pal) begin
      pal[pal_idx] <= pwdata;
    end
  end

  function automatic logic [7:0] id_byte(input logic [2:0] k);
    case (k)
      3'd0: id_byte = 8'h10;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    prdata = '0;
    if (in_pal) begin
      prdata = pal[pal_idx];
    end else if (in_id) begin
      prdata = {24'd0, id_byte(paddr[4:2])};
    end else if (in_reg) begin
      case (idx)
        10'd0, 10'd1, 10'd2, 10'd3: prdata = tim[idx[1:0]];
        10'd4: prdata = upper_base;
        10'd5: prdata = lower_base;
        10'd6: prdata = 32'(mask);
        10'd7: prdata = ctrl;
        10'd8: prdata = 32'(raw);
        10'd9: prdata = 32'(masked);
        default: prdata = '0;
      endcase
    end
  end

  assign irq         = |masked;
  assign enabled     = ctrl[0] & ctrl[11];
  assign depth       = ctrl[3:1];
  assign bgr_swap    = ctrl[8];
  assign be_bytes    = ctrl[9];
  assign be_pixels   = ctrl[10];
  assign line_pixels = {7'(tim[0][7:2]) + 7'd1, 4'b0000};
  assign frame_lines = {1'b0, tim[1][9:0]} + 11'd1;
endmodule

module lcd_regbank_chk #(
  parameter int NSTAT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [11:0]      paddr,
  input logic [31:0]      pwdata,
  input logic [31:0]      prdata,
  input logic [NSTAT-1:0] sts_set,
  input logic [NSTAT-1:0] raw,
  input logic             irq,
  input logic             enabled,
  input logic [10:0]      frame_lines,
  input logic             inval
);
  wire       acc_wr  = psel && penable && pwrite;
  wire [9:0] widx    = paddr[11:2];
  wire       cfg_hit = acc_wr && (paddr[11:4] == 8'd0 || widx == 10'd7);

  a_r10_pulse_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> inval);
  a_r10_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> !inval);
  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_set != '0) |=> ((raw & $past(sts_set)) == $past(sts_set)));
  a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && widx == 10'd10 && (&pwdata[NSTAT-1:0]) && sts_set == '0) |=> (raw == '0));
  a_r8_irq_vs_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && widx == 10'd9) |-> (irq == (prdata != 32'd0)));
  a_r5_enable_vs_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && widx == 10'd7) |-> (enabled == (prdata[0] && prdata[11])));
  a_r9_current_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && (widx == 10'd11 || widx == 10'd12)) |-> (prdata == 32'd0));
  a_r4_lines_vs_timing1: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && widx == 10'd1) |-> (frame_lines == {1'b0, prdata[9:0]} + 11'd1));
endmodule

bind lcd_regbank lcd_regbank_chk #(.NSTAT(NSTAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sts_set(sts_set),
  .raw(raw), .irq(irq), .enabled(enabled), .frame_lines(frame_lines),
  .inval(inval)
);

// File: tb/tb_lcd_regbank.sv
module tb_lcd_regbank;
  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic [3:0] sts_set = 0;
  logic irq, enabled, bgr_swap, be_bytes, be_pixels, inval;
  logic [2:0] depth;
  logic [10:0] line_pixels, frame_lines;
  logic [31:0] upper_base, lower_base;

  always #2 clk = ~clk;

  lcd_regbank dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // behavioural reference state
  int unsigned m_tim [4];
  int unsigned m_up, m_lo, m_ctrl, m_mask, m_raw;
  int unsigned m_pal [128];
  bit m_inval;
  byte unsigned idb [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  initial begin
    for (int i = 0; i < 4; i++) m_tim[i] = 0;
    for (int i = 0; i < 128; i++) m_pal[i] = 0;
    m_up = 0; m_lo = 0; m_ctrl = 0; m_mask = 0; m_raw = 0; m_inval = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      int a;
      int unsigned c;
      a = int'(paddr);
      c = 0;
      m_inval <= 0;
      if (psel && penable && pwrite) begin
        if (a >= 'h200 && a < 'h400) m_pal[(a - 'h200) / 4] <= pwdata;
        else if (a < 'h40) begin
          case (a / 4)
            0, 1, 2, 3: begin m_tim[a / 4] <= pwdata; m_inval <= 1; end
            4: m_up <= pwdata;
            5: m_lo <= pwdata;
            6: m_mask <= pwdata & 32'hF;
            7: begin m_ctrl <= pwdata; m_inval <= 1; end
            10: c = pwdata & 32'hF;
            default: ;
          endcase
        end
      end
      m_raw <= (m_raw & ~c) | 32'(sts_set);
    end
  end

  function automatic int unsigned exp_rd(input int a);
    if (a >= 'h200 && a < 'h400) return m_pal[(a - 'h200) / 4];
    if (a >= 'hFE0) return 32'(idb[(a - 'hFE0) / 4]);
    if (a < 'h40) begin
      case (a / 4)
        0, 1, 2, 3: return m_tim[a / 4];
        4: return m_up;
        5: return m_lo;
        6: return m_mask;
        7: return m_ctrl;
        8: return m_raw;
        9: return m_raw & m_mask;
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input int unsigned act, input int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R11 covered by these comparisons in the cycles right after reset
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 line_pixels", 32'(line_pixels), ((m_tim[0] & 32'hFC) + 4) * 4);
      chk("R4 frame_lines", 32'(frame_lines), (m_tim[1] & 32'h3FF) + 1);
      chk("R5 enabled", 32'(enabled), 32'(m_ctrl[0] & m_ctrl[11]));
      chk("R5 depth", 32'(depth), (m_ctrl >> 1) & 7);
      chk("R5 flags", {29'd0, be_pixels, be_bytes, bgr_swap}, (m_ctrl >> 8) & 7);
      chk("R1 bases", upper_base ^ lower_base, m_up ^ m_lo);
      chk("R1 upper_base", upper_base, m_up);
      chk("R8 irq", 32'(irq), 32'((m_raw & m_mask) != 0));
      chk("R10 inval", 32'(inval), 32'(m_inval));
      if (psel) chk($sformatf("R1 R2 R3 R9 read @%0h", paddr), prdata, exp_rd(int'(paddr)));
    end
  end

  task automatic acc(input bit w, input int a, input int unsigned d);
    @(posedge clk); #1;
    psel = 1; penable = 0; pwrite = w; paddr = 12'(a); pwdata = d;
    @(posedge clk); #1;
    penable = 1;
    @(posedge clk); #1;
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic wr(input int a, input int unsigned d); acc(1, a, d); endtask
  task automatic rd(input int a); acc(0, a, 0); endtask

  task automatic pulse_set(input logic [3:0] s);
    @(posedge clk); #1; sts_set = s;
    @(posedge clk); #1; sts_set = 0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          total++; bad++;
          $display("FAIL watchdog actual=hung expected=finished");
          done = 1;
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R11 reset state reads
    for (int i = 0; i < 13; i++) rd(i * 4);
    // R1 register readback
    for (int i = 0; i < 4; i++) wr(i * 4, 32'hA5A50000 + i * 32'h1111);
    wr('h10, 32'h8000_1000); wr('h14, 32'h0123_4567);
    wr('h18, 32'hFFFF_FFF5);
    for (int i = 0; i < 8; i++) rd(i * 4);
    // R4 boundaries
    wr('h00, 32'h0000_0000); wr('h00, 32'h0000_00FF); wr('h00, 32'hFFFF_FF03);
    wr('h04, 32'h0000_03FF); wr('h04, 32'h0000_0000); wr('h04, 32'hFFFF_FC2A);
    // R5 control combos, R10 pulses
    wr('h1C, 32'h0000_0001); wr('h1C, 32'h0000_0800); wr('h1C, 32'h0000_0F0F);
    wr('h1C, 32'h0000_0A05); rd('h1C);
    // R3 palette
    wr('h200, 32'hDEAD_BEEF); wr('h3FC, 32'h1234_5678); wr('h2A4, 32'h0F0F_F0F0);
    for (int i = 0; i < 16; i++) wr('h200 + i * 8, $urandom);
    rd('h200); rd('h3FC); rd('h2A4);
    for (int i = 0; i < 32; i++) rd('h200 + i * 4);
    // R2 identification
    for (int i = 0; i < 8; i++) rd('hFE0 + i * 4);
    // R6 R7 R8 status
    wr('h18, 32'h0000_0005);
    pulse_set(4'b0011); rd('h20); rd('h24);
    pulse_set(4'b1100); rd('h20); rd('h24);
    wr('h28, 32'h0000_0001); rd('h20); rd('h24);
    wr('h28, 32'h0000_000F); rd('h20); rd('h24);
    pulse_set(4'b0100);
    @(posedge clk); #1; psel = 1; pwrite = 1; paddr = 12'h028; pwdata = 32'hF;
    @(posedge clk); #1; penable = 1; sts_set = 4'b0100;
    @(posedge clk); #1; psel = 0; penable = 0; pwrite = 0; sts_set = 0;
    rd('h20); rd('h28);
    wr('h18, 32'h0); rd('h24); wr('h18, 32'hF); rd('h24);
    // R9 unmapped and read-only
    wr('h20, 32'hFFFF_FFFF); wr('h24, 32'hFFFF_FFFF); wr('h2C, 32'hFFFF_FFFF);
    wr('h30, 32'hFFFF_FFFF); wr('h40, 32'h5555_5555); wr('h1FC, 32'h7777_7777);
    wr('h400, 32'h9999_9999); wr('hFDC, 32'h3333_3333); wr('hFE0, 32'hFFFF_FFFF);
    rd('h2C); rd('h30); rd('h40); rd('h1FC); rd('h400); rd('hFDC); rd('hFE0);
    for (int i = 0; i < 13; i++) rd(i * 4);
    for (int i = 0; i < 50; i++) begin
      int a;
      a = ($urandom % 1024) * 4;
      if ($urandom % 2) wr(a, $urandom); else rd(a);
      if ($urandom % 4 == 0) pulse_set(4'($urandom));
    end
    repeat (4) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule